// File: doc/BRIEF.md
# Two-Dimensional Transfer Address Generator

This block walks a rectangular region of memory and issues one byte address per beat. Software programs a base address, a count of elements per row, a count of rows, an element size of 16 or 32 bits and a signed row-to-row byte stride. A start pulse begins the walk. Inside a row the address advances by the element size. After the last element of a row the programmed row stride is added in place of the element size. A window inside a larger framebuffer is therefore walked by setting the row stride to the gap between rows plus one element.

Addresses leave the block on a valid/ready handshake, and the block moves no data. A finished walk either stops and raises a sticky done flag, which is cleared by writing one, or starts over from the base address without software action, for continuous display refresh. The run status stays high while addresses are being issued. A zero count raises an error flag instead of starting. Dropping the enable ends the walk at the next accepted beat and resets the counters.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, beat_valid, sts_run, sts_done and sts_err are all 0.
- R2: A ctl_start pulse with ctl_enable high, an idle block and both counts nonzero raises beat_valid and sts_run on the next cycle, with beat_addr equal to cfg_start_addr. While beat_valid is high and beat_ready is low, beat_valid and beat_addr hold. A ctl_start pulse with ctl_enable low has no effect.
- R3: After an accepted beat that is not the last of its row, the address increases by 2 when beat_wide is 0 (16-bit elements) or by 4 when beat_wide is 1 (32-bit elements).
- R4: After the accepted last beat of a row, other than the final beat, cfg_outer_stride (signed two's complement, sign-extended, with wraparound modulo 2^ADDR_W) is added to the address. The element count restarts for the next row.
- R5: A walk issues exactly inner count × outer count beats. When autobuffer is off (cfg_autobuf = 0), the cycle after the final beat is accepted has beat_valid and sts_run low and sts_done high.
- R6: sts_done stays high until a ctl_done_clr pulse, which clears it on the next cycle.
- R7: With cfg_autobuf = 1, the beat after the final one carries the base address again. The walk repeats with the same counts, sts_run stays high and sts_done is not set.
- R8: A start with cfg_inner_cnt = 0 or cfg_outer_cnt = 0 sets sts_err on the next cycle and issues no beat. The next successful start clears sts_err.
- R9: With ctl_enable low during a walk, the pending beat stays valid until it is accepted. On the next cycle beat_valid and sts_run are low and sts_done is not set. A later start begins again from the base address.
- R10: Configuration is captured at start. Changes to the cfg_ inputs during a walk, and further start pulses during a walk, have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start_addr | input | ADDR_W | Base byte address of the region |
| cfg_inner_cnt | input | CNT_W | Elements per row |
| cfg_outer_cnt | input | CNT_W | Rows per walk |
| cfg_outer_stride | input | STRIDE_W | Signed byte step added after a row's last element |
| cfg_wide | input | 1 | Element size: 0 = 16 bits, 1 = 32 bits |
| cfg_autobuf | input | 1 | Restart automatically after the final beat |
| ctl_enable | input | 1 | Walk enable; low aborts at the next accepted beat |
| ctl_start | input | 1 | One-cycle start request |
| ctl_done_clr | input | 1 | Write-one pulse clearing sts_done |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_wide | output | 1 | Element size of the current beat |
| beat_valid | output | 1 | Address is valid |
| beat_ready | input | 1 | Consumer accepts the address |
| sts_run | output | 1 | Walk active |
| sts_done | output | 1 | Sticky completion flag |
| sts_err | output | 1 | Zero-count configuration error |

## Verification
The assertions assume that beat_ready is a clean level from the consumer. They also assume that ctl_start, ctl_done_clr and ctl_enable change only between edges. The hold property assumes nothing else moves the address while a beat is stalled. The bench drives every input at the falling clock edge. It chooses beat_ready at random per cycle, with a stall probability set per test, and it keeps counts small and strides even so that each whole walk can be predicted beat by beat. Zero counts, disable during a stall and reconfiguration mid-walk are covered by directed cases and not left to chance.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    // Command from the control unit to the counter and address units.
    typedef struct packed {
        logic load;   // take initial values
        logic step;   // advance by one accepted beat
        logic clear;  // return to zero
    } walk_cmd_t;

    typedef struct packed {
        logic run;
        logic done;
        logic err;
    } walk_flags_t;

endpackage

// File: rtl/dma2d_counters.sv
module dma2d_counters
    import dma2d_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  walk_cmd_t        cmd,
    input  logic [CNT_W-1:0] inner_val,
    input  logic [CNT_W-1:0] outer_val,
    output logic             row_end,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] icnt;
        logic [CNT_W-1:0] ocnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd.clear) begin
            st_d = '0;
        end else if (cmd.load) begin
            st_d.icnt = inner_val;
            st_d.ocnt = outer_val;
        end else if (cmd.step) begin
            if (st_q.icnt != ONE) begin
                st_d.icnt = st_q.icnt - ONE;
            end else if (st_q.ocnt != ONE) begin
                st_d.icnt = inner_val;
                st_d.ocnt = st_q.ocnt - ONE;
            end else begin
                st_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_end = (st_q.icnt == ONE);
    assign last    = row_end && (st_q.ocnt == ONE);

    // R5: a step is never applied to an exhausted counter
    a_r5_no_step_empty: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.step |-> (st_q.icnt != '0) && (st_q.ocnt != '0));

    // R4: the element counter restarts from the row length after a row end
    a_r4_row_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.step && !cmd.load && !cmd.clear && row_end && !last)
        |=> st_q.icnt == $past(inner_val));

endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr
    import dma2d_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  walk_cmd_t                  cmd,
    input  logic [ADDR_W-1:0]          ld_addr,
    input  logic                       row_end,
    input  logic                       wide,
    input  logic signed [STRIDE_W-1:0] outer_stride,
    output logic [ADDR_W-1:0]          addr
);
    localparam int EXT_W = ADDR_W - STRIDE_W;
    localparam logic [ADDR_W-1:0] STEP16 = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP32 = ADDR_W'(4);

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [ADDR_W-1:0] inner_inc;
    logic [ADDR_W-1:0] outer_inc;

    always_comb begin
        inner_inc = wide ? STEP32 : STEP16;
        outer_inc = {{EXT_W{outer_stride[STRIDE_W-1]}}, outer_stride};
        addr_d    = addr_q;
        if (cmd.clear)       addr_d = '0;
        else if (cmd.load)   addr_d = ld_addr;
        else if (cmd.step)   addr_d = addr_q + (row_end ? outer_inc : inner_inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

    // R3: in-row step equals the element size in bytes
    a_r3_inner_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.step && !cmd.load && !cmd.clear && !row_end)
        |=> (addr_q - $past(addr_q)) == ($past(wide) ? STEP32 : STEP16));

    // R7: a load returns the address to the supplied base
    a_r7_load_base: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.load && !cmd.clear) |=> addr_q == $past(ld_addr));

endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
    import dma2d_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          cfg_start_addr,
    input  logic [CNT_W-1:0]           cfg_inner_cnt,
    input  logic [CNT_W-1:0]           cfg_outer_cnt,
    input  logic signed [STRIDE_W-1:0] cfg_outer_stride,
    input  logic                       cfg_wide,
    input  logic                       cfg_autobuf,
    input  logic                       ctl_enable,
    input  logic                       ctl_start,
    input  logic                       ctl_done_clr,
    input  logic                       beat_ready,
    input  logic                       last,
    output walk_cmd_t                  cmd,
    output logic [ADDR_W-1:0]          ld_addr,
    output logic [CNT_W-1:0]           inner_val,
    output logic [CNT_W-1:0]           outer_val,
    output logic                       sh_wide,
    output logic signed [STRIDE_W-1:0] sh_outer_stride,
    output walk_flags_t                flags
);
    typedef struct packed {
        logic [ADDR_W-1:0]          start;
        logic [CNT_W-1:0]           inner;
        logic [CNT_W-1:0]           outer;
        logic signed [STRIDE_W-1:0] ostride;
        logic                       wide;
        logic                       autobuf;
        walk_flags_t                fl;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic launch, bad_cfg, accept;

    always_comb begin
        launch    = ctl_start && ctl_enable && !st_q.fl.run;
        bad_cfg   = (cfg_inner_cnt == '0) || (cfg_outer_cnt == '0);
        accept    = st_q.fl.run && beat_ready;

        st_d      = st_q;
        cmd       = '0;
        ld_addr   = st_q.start;
        inner_val = st_q.inner;
        outer_val = st_q.outer;

        if (ctl_done_clr) st_d.fl.done = 1'b0;

        if (launch) begin
            if (bad_cfg) begin
                st_d.fl.err = 1'b1;
            end else begin
                st_d.start   = cfg_start_addr;
                st_d.inner   = cfg_inner_cnt;
                st_d.outer   = cfg_outer_cnt;
                st_d.ostride = cfg_outer_stride;
                st_d.wide    = cfg_wide;
                st_d.autobuf = cfg_autobuf;
                st_d.fl.run  = 1'b1;
                st_d.fl.err  = 1'b0;
                cmd.load     = 1'b1;
                ld_addr      = cfg_start_addr;
                inner_val    = cfg_inner_cnt;
                outer_val    = cfg_outer_cnt;
            end
        end else if (accept) begin
            if (!ctl_enable) begin
                st_d.fl.run = 1'b0;
                cmd.clear   = 1'b1;
            end else if (last) begin
                if (st_q.autobuf) begin
                    cmd.load = 1'b1;
                end else begin
                    st_d.fl.run  = 1'b0;
                    st_d.fl.done = 1'b1;
                    cmd.clear    = 1'b1;
                end
            end else begin
                cmd.step = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags           = st_q.fl;
    assign sh_wide         = st_q.wide;
    assign sh_outer_stride = st_q.ostride;

    // R5: done only rises as the walk stops
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fl.done) |-> !st_q.fl.run);

    // R8: an error never coexists with an active walk
    a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fl.err |-> !st_q.fl.run);

    // R9: an accepted beat with enable low ends the walk without done
    a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fl.run && beat_ready && !ctl_enable)
        |=> !st_q.fl.run && !$rose(st_q.fl.done));

    // R10: captured configuration is stable while running
    a_r10_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fl.run && $past(st_q.fl.run)) |-> $stable(st_q.start) && $stable(st_q.inner));

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          cfg_start_addr,
    input  logic [CNT_W-1:0]           cfg_inner_cnt,
    input  logic [CNT_W-1:0]           cfg_outer_cnt,
    input  logic signed [STRIDE_W-1:0] cfg_outer_stride,
    input  logic                       cfg_wide,
    input  logic                       cfg_autobuf,
    input  logic                       ctl_enable,
    input  logic                       ctl_start,
    input  logic                       ctl_done_clr,
    output logic [ADDR_W-1:0]          beat_addr,
    output logic                       beat_wide,
    output logic                       beat_valid,
    input  logic                       beat_ready,
    output logic                       sts_run,
    output logic                       sts_done,
    output logic                       sts_err
);
    walk_cmd_t                  cmd;
    walk_flags_t                flags;
    logic [ADDR_W-1:0]          ld_addr;
    logic [CNT_W-1:0]           inner_val, outer_val;
    logic                       sh_wide;
    logic signed [STRIDE_W-1:0] sh_outer_stride;
    logic                       row_end, last;

    dma2d_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_addr(cfg_start_addr), .cfg_inner_cnt(cfg_inner_cnt),
        .cfg_outer_cnt(cfg_outer_cnt), .cfg_outer_stride(cfg_outer_stride),
        .cfg_wide(cfg_wide), .cfg_autobuf(cfg_autobuf),
        .ctl_enable(ctl_enable), .ctl_start(ctl_start), .ctl_done_clr(ctl_done_clr),
        .beat_ready(beat_ready), .last(last),
        .cmd(cmd), .ld_addr(ld_addr), .inner_val(inner_val), .outer_val(outer_val),
        .sh_wide(sh_wide), .sh_outer_stride(sh_outer_stride), .flags(flags)
    );

    dma2d_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .inner_val(inner_val), .outer_val(outer_val),
        .row_end(row_end), .last(last)
    );

    dma2d_addr #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ld_addr(ld_addr),
        .row_end(row_end), .wide(sh_wide), .outer_stride(sh_outer_stride),
        .addr(beat_addr)
    );

    assign beat_wide  = sh_wide;
    assign beat_valid = flags.run;
    assign sts_run    = flags.run;
    assign sts_done   = flags.done;
    assign sts_err    = flags.err;

    // R2: a stalled beat keeps its address and validity
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> beat_valid && $stable(beat_addr));

    // R6: done clears only on a clear pulse
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_done && !ctl_done_clr) |=> sts_done);

endmodule

// File: tb/dma2d_addr_gen_test.sv
module dma2d_addr_gen_test;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int SW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] cfg_start_addr = '0;
    logic [CW-1:0] cfg_inner_cnt = '0, cfg_outer_cnt = '0;
    logic signed [SW-1:0] cfg_outer_stride = '0;
    logic cfg_wide = 1'b0, cfg_autobuf = 1'b0;
    logic ctl_enable = 1'b0, ctl_start = 1'b0, ctl_done_clr = 1'b0;
    logic beat_ready = 1'b0;
    logic [AW-1:0] beat_addr;
    logic beat_wide, beat_valid, sts_run, sts_done, sts_err;

    dma2d_addr_gen uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_addr(cfg_start_addr), .cfg_inner_cnt(cfg_inner_cnt),
        .cfg_outer_cnt(cfg_outer_cnt), .cfg_outer_stride(cfg_outer_stride),
        .cfg_wide(cfg_wide), .cfg_autobuf(cfg_autobuf),
        .ctl_enable(ctl_enable), .ctl_start(ctl_start), .ctl_done_clr(ctl_done_clr),
        .beat_addr(beat_addr), .beat_wide(beat_wide), .beat_valid(beat_valid),
        .beat_ready(beat_ready), .sts_run(sts_run), .sts_done(sts_done), .sts_err(sts_err)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // reference walk state
    logic [AW-1:0] m_start, m_addr;
    int m_inner, m_outer, m_ic, m_oc, m_is, m_os;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_next();
        if (m_ic > 1) begin
            m_addr = m_addr + AW'(m_is);
            m_ic--;
        end else if (m_oc > 1) begin
            m_addr = m_addr + AW'(m_os);
            m_ic = m_inner;
            m_oc--;
        end else begin
            m_addr = m_start;
            m_ic = m_inner;
            m_oc = m_outer;
        end
    endtask

    task automatic start_xfer(input logic [AW-1:0] sa, input int ni, input int no,
                              input int os, input bit wide, input bit ab);
        @(negedge clk);
        cfg_start_addr = sa; cfg_inner_cnt = CW'(ni); cfg_outer_cnt = CW'(no);
        cfg_outer_stride = SW'(os); cfg_wide = wide; cfg_autobuf = ab;
        ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
        m_start = sa; m_addr = sa; m_inner = ni; m_outer = no;
        m_ic = ni; m_oc = no; m_is = wide ? 4 : 2; m_os = os;
        chk(beat_valid && sts_run, "R2", "valid after start", {62'd0, beat_valid, sts_run}, 64'd3);
        chk(beat_addr == sa, "R2", "first address", beat_addr, sa);
        chk(beat_wide == wide, "R3", "element size", beat_wide, wide);
    endtask

    // R3 R4: compare each accepted address with the reference walk
    task automatic run_beats(input int nbeats, input int pct);
        int got = 0;
        bit prev_stall = 1'b0;
        logic [AW-1:0] prev_a = '0;
        while (got < nbeats) begin
            @(negedge clk);
            if (prev_stall)
                chk(beat_addr == prev_a, "R2", "stalled address held", beat_addr, prev_a);
            chk(beat_valid, "R5", "valid inside walk", beat_valid, 1);
            beat_ready = ($urandom_range(99) < pct);
            if (beat_ready) begin
                chk(beat_addr == m_addr, "R3 R4", "beat address", beat_addr, m_addr);
                model_next();
                got++;
            end
            prev_stall = !beat_ready;
            prev_a = beat_addr;
        end
        @(negedge clk);
        beat_ready = 1'b0;
    endtask

    task automatic finish_check();
        chk(!beat_valid && !sts_run, "R5", "stopped after final beat", {62'd0, beat_valid, sts_run}, 0);
        chk(sts_done, "R5", "done after final beat", sts_done, 1);
        @(negedge clk); @(negedge clk);
        chk(sts_done, "R6", "done sticky", sts_done, 1);
        ctl_done_clr = 1'b1;
        @(negedge clk);
        ctl_done_clr = 1'b0;
        chk(!sts_done, "R6", "done cleared", sts_done, 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!beat_valid && !sts_run && !sts_done && !sts_err, "R1", "reset flags",
            {60'd0, beat_valid, sts_run, sts_done, sts_err}, 0);
        rst_n = 1'b1;

        // R2: start ignored while disabled
        @(negedge clk);
        cfg_inner_cnt = 2; cfg_outer_cnt = 2; ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
        chk(!beat_valid, "R2", "start without enable", beat_valid, 0);
        ctl_enable = 1'b1;

        // directed: 32-bit elements, positive row stride
        start_xfer(32'h0000_1000, 3, 2, 100, 1'b1, 1'b0);
        run_beats(6, 70);
        finish_check();

        // directed: window in a 480-wide, 3-byte-per-pixel buffer, 16-bit elements
        begin
            int w = 4, x = 7, y = 5;
            logic [AW-1:0] sa;
            sa = 32'h2000_0000 + AW'((x & ~1) * 3) + AW'(y * 480 * 3);
            start_xfer(sa, w * 3 / 2, 3, (480 - w) * 3 + 2, 1'b0, 1'b0);
            run_beats(18, 60);
            finish_check();
        end

        // directed: negative row stride
        start_xfer(32'h0000_0400, 2, 3, -40, 1'b1, 1'b0);
        run_beats(6, 100);
        finish_check();

        // directed: single-element walk
        start_xfer(32'h0000_0010, 1, 1, 8, 1'b0, 1'b0);
        run_beats(1, 100);
        finish_check();

        // random walks
        for (int k = 0; k < 10; k++) begin
            int ni, no, os, pct;
            bit wd;
            ni = 1 + $urandom_range(4);
            no = 1 + $urandom_range(3);
            os = 2 * ($urandom_range(64) - 32);
            wd = $urandom_range(1);
            pct = 30 + $urandom_range(70);
            start_xfer($urandom() & 32'hFFFF_FFFC, ni, no, os, wd, 1'b0);
            run_beats(ni * no, pct);
            finish_check();
        end

        // R7 autobuffer wrap, then R9 abort while stalled
        start_xfer(32'h0000_8000, 3, 2, 20, 1'b1, 1'b1);
        run_beats(16, 80);
        chk(sts_run && !sts_done, "R7", "autobuffer keeps running", {62'd0, sts_run, sts_done}, 2);
        begin
            logic [AW-1:0] held;
            @(negedge clk);
            ctl_enable = 1'b0;
            held = beat_addr;
            repeat (3) begin
                @(negedge clk);
                chk(beat_valid && beat_addr == held, "R9", "pending beat held while disabled", beat_addr, held);
            end
            beat_ready = 1'b1;
            @(negedge clk);
            beat_ready = 1'b0;
            chk(!beat_valid && !sts_run && !sts_done, "R9", "abort stops without done",
                {61'd0, beat_valid, sts_run, sts_done}, 0);
            ctl_enable = 1'b1;
        end
        // R9: fresh start after abort
        start_xfer(32'h0000_8000, 2, 2, 12, 1'b0, 1'b0);
        run_beats(4, 90);
        finish_check();

        // R8 zero counts
        @(negedge clk);
        cfg_inner_cnt = 0; cfg_outer_cnt = 3; ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
        chk(sts_err && !beat_valid, "R8", "zero inner count", {62'd0, sts_err, beat_valid}, 2);
        @(negedge clk);
        chk(!beat_valid, "R8", "no beat after error", beat_valid, 0);
        cfg_inner_cnt = 3; cfg_outer_cnt = 0; ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
        chk(sts_err && !beat_valid, "R8", "zero outer count", {62'd0, sts_err, beat_valid}, 2);
        start_xfer(32'h0000_0100, 2, 1, 0, 1'b1, 1'b0);
        chk(!sts_err, "R8", "error cleared by start", sts_err, 0);
        run_beats(2, 100);
        finish_check();

        // R10 config captured at start
        start_xfer(32'h0000_3000, 2, 2, 64, 1'b1, 1'b0);
        @(negedge clk);
        cfg_start_addr = 32'hDEAD_0000; cfg_inner_cnt = 7; cfg_outer_cnt = 5;
        cfg_outer_stride = -16'sd2; cfg_wide = 1'b0; cfg_autobuf = 1'b1;
        ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
        chk(beat_addr == 32'h0000_3000, "R10", "restart ignored while running", beat_addr, 32'h0000_3000);
        run_beats(4, 75);
        finish_check();

        summary();
        $finish;
    end
endmodule